// File: doc/BRIEF.md
# Serial Line Transmit Framer with Stick Parity

This block turns a parallel character into an asynchronous serial frame. A character is offered with a valid/ready handshake. The frame is then built from an 8-bit line control byte. The block sends a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one, one and a half or two high stop bits. An external baud-tick enable sets the timing, and every bit lasts a fixed number of ticks.

The parity bit can carry odd parity or even parity, or it can be stuck at mark or at space. A break control forces the line low no matter what the shifter is doing. The shifter keeps running under break, so a character accepted during break is used up without appearing on the line. One control bit does not affect the frame at all. It is only passed on as a registered register-select output for the bus logic around the block.

The control byte is captured when a character is accepted. Any later change to it applies from the next frame on. Break and register-select are the exceptions: they follow the control byte live.

Top module: `uart_stick_tx`

## Requirements
- R1: During and right after reset, `txd` is 1 (mark), `tx_ready` is 1 and `div_sel` is 0.
- R2: A frame is one start bit at 0, then the data bits with the LSB first, then the stop bits at 1. The data width comes from control bits 1:0, where 00, 01, 10 and 11 give 5, 6, 7 and 8 bits. Unused upper data bits are not sent.
- R3: When control bit 3 is 0, no parity bit is sent, whatever bits 5:4 hold.
- R4: With bit 3 = 1 and bits 5:4 = 00, the parity bit makes the count of 1s over the data and parity bits odd.
- R5: With bit 3 = 1 and bits 5:4 = 01, the count of 1s over the data and parity bits is even.
- R6: With bit 3 = 1 and bits 5:4 = 10, the parity bit is 1.
- R7: With bit 3 = 1 and bits 5:4 = 11, the parity bit is 0.
- R8: When control bit 2 is 0, the stop time is 16 ticks. When it is 1, the stop time is 32 ticks, or 24 ticks for 5-bit characters.
- R9: While control bit 6 is 1, `txd` is 0 from the second clock edge after bit 6 is set. A character accepted during break still takes its full frame time and is then dropped. About two cycles after bit 6 is cleared on an idle block, `txd` is 1 again.
- R10: `div_sel` shows control bit 7 one clock later. It has no effect on the frame.
- R11: `tx_ready` is 1 only when no frame is in progress. It drops in the cycle after a character is accepted and comes back after the last stop tick.
- R12: The control bits that shape the frame (1:0, 2, 3, 5:4) are captured on acceptance. Changes made in the middle of a frame do not alter that frame.
- R13: The start bit, each data bit and the parity bit each last 16 baud ticks. The tick counting starts in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle baud enable, 16 per bit |
| lcr | input | 8 | Line control byte |
| tx_valid | input | 1 | Character offered |
| tx_data | input | 8 | Character to send |
| tx_ready | output | 1 | High when idle and able to accept |
| txd | output | 1 | Serial line, registered, idles high |
| div_sel | output | 1 | Registered register-select (divisor side when 1) |

## Verification
A character is accepted on the edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is low at the next falling edge. The first baud tick that counts is the one visible in the cycle after acceptance. The bench therefore counts ticks from the falling edge that follows acceptance. It samples bit k at tick 16k+8, reads the line in the middle of the bit, and requires the total tick count up to `tx_ready` returning to equal 16×(1+n+p) plus the stop length exactly. `txd` and `div_sel` each sit one register behind their control inputs. The bench checks them at the falling edge one full cycle after it drives the change.

// File: rtl/uart_stick_pkg.sv
package uart_stick_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_t;

  typedef struct packed {
    logic [1:0] wlen;      // 0..3 -> 5..8 data bits
    logic       two_stop;
    logic       par_en;
    logic       par_even;  // also selects space when stuck
    logic       par_stick;
  } frame_cfg_t;

  function automatic frame_cfg_t decode_ctrl(input logic [7:0] c);
    frame_cfg_t f;
    f.wlen      = c[1:0];
    f.two_stop  = c[2];
    f.par_en    = c[3];
    f.par_even  = c[4];
    f.par_stick = c[5];
    return f;
  endfunction

endpackage

// File: rtl/uart_parity_gen.sv
module uart_parity_gen #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,   // already masked to word length
  input  logic              even_i,
  input  logic              stick_i,
  output logic              par_o
);
  logic ones_odd;
  assign ones_odd = ^data_i;

  always_comb begin
    if (stick_i)      par_o = ~even_i;     // 10 -> mark, 11 -> space
    else if (even_i)  par_o = ones_odd;
    else              par_o = ~ones_odd;
  end
endmodule

// File: rtl/uart_bit_timer.sv
module uart_bit_timer #(
  parameter int TICKS_PER_BIT = 16,
  localparam int CNT_W = $clog2(2 * TICKS_PER_BIT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q == lim_i - CNT_W'(1));
  assign done_o = tick_i && at_end && !clear_i;

  always_ff @(posedge clk) begin
    if (rst || clear_i)  cnt_q <= '0;
    else if (tick_i)     cnt_q <= at_end ? '0 : cnt_q + CNT_W'(1);
  end

  assert_cnt_in_bit_R13: assert property (@(posedge clk) disable iff (rst)
    !clear_i |=> (cnt_q < lim_i || clear_i));
endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
  import uart_stick_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16,
  localparam int CNT_W = $clog2(2 * TICKS_PER_BIT + 1),
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [7:0]        ctrl_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ready_o,
  output logic              line_o
);
  localparam logic [CNT_W-1:0] BIT_LIM  = CNT_W'(TICKS_PER_BIT);
  localparam logic [CNT_W-1:0] HALF3    = CNT_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2);
  localparam logic [CNT_W-1:0] DBL_LIM  = CNT_W'(2 * TICKS_PER_BIT);

  tx_state_t         state_q;
  frame_cfg_t        cfg_q, cfg_new;
  logic [DATA_W-1:0] sh_q, masked;
  logic [IDX_W-1:0]  idx_q, last_idx;
  logic              par_q, par_new, done, accept;
  logic [CNT_W-1:0]  stop_lim, lim;

  assign cfg_new = decode_ctrl(ctrl_i);
  assign ready_o = (state_q == ST_IDLE);
  assign accept  = ready_o && valid_i;

  always_comb begin
    for (int i = 0; i < DATA_W; i++)
      masked[i] = (i < 5 + int'(cfg_new.wlen)) ? data_i[i] : 1'b0;
  end

  uart_parity_gen #(.DATA_W(DATA_W)) par_i (
    .data_i (masked),
    .even_i (cfg_new.par_even),
    .stick_i(cfg_new.par_stick),
    .par_o  (par_new)
  );

  always_comb begin
    if (!cfg_q.two_stop)        stop_lim = BIT_LIM;
    else if (cfg_q.wlen == 2'd0) stop_lim = HALF3;
    else                         stop_lim = DBL_LIM;
  end
  assign lim      = (state_q == ST_STOP) ? stop_lim : BIT_LIM;
  assign last_idx = IDX_W'(4) + IDX_W'(cfg_q.wlen);

  uart_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) tmr_i (
    .clk    (clk),
    .rst    (rst),
    .clear_i(state_q == ST_IDLE),
    .tick_i (tick_i),
    .lim_i  (lim),
    .done_o (done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      sh_q    <= '0;
      idx_q   <= '0;
      par_q   <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          cfg_q   <= cfg_new;
          sh_q    <= masked;
          par_q   <= par_new;
          idx_q   <= '0;
          state_q <= ST_START;
        end
        ST_START: if (done) state_q <= ST_DATA;
        ST_DATA: if (done) begin
          sh_q <= sh_q >> 1;
          if (idx_q == last_idx) state_q <= cfg_q.par_en ? ST_PAR : ST_STOP;
          else                   idx_q   <= idx_q + IDX_W'(1);
        end
        ST_PAR:  if (done) state_q <= ST_STOP;
        ST_STOP: if (done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      ST_START: line_o = 1'b0;
      ST_DATA:  line_o = sh_q[0];
      ST_PAR:   line_o = par_q;
      default:  line_o = 1'b1;
    endcase
  end

  assert_ready_drops_R11: assert property (@(posedge clk) disable iff (rst)
    (valid_i && ready_o) |=> !ready_o);
  assert_cfg_held_R12: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |=> (state_q == ST_IDLE || $stable(cfg_q)));
  assert_par_only_enabled_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PAR) |-> cfg_q.par_en);
endmodule

// File: rtl/uart_stick_tx.sv
module uart_stick_tx #(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic [7:0]        lcr,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              txd,
  output logic              div_sel
);
  logic line;

  uart_tx_fsm #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) fsm_i (
    .clk    (clk),
    .rst    (rst),
    .tick_i (baud_tick),
    .ctrl_i (lcr),
    .valid_i(tx_valid),
    .data_i (tx_data),
    .ready_o(tx_ready),
    .line_o (line)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      txd     <= 1'b1;
      div_sel <= 1'b0;
    end else begin
      txd     <= line & ~lcr[6];
      div_sel <= lcr[7];
    end
  end

  assert_idle_mark_R1: assert property (@(posedge clk) disable iff (rst)
    (tx_ready && !lcr[6]) |=> txd);
  assert_break_space_R9: assert property (@(posedge clk) disable iff (rst)
    lcr[6] |=> !txd);
endmodule

// File: tb/uart_stick_tx_tb_top.sv
module uart_stick_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic [7:0] lcr = 8'h00;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_ready, txd, div_sel;

  int n_run = 0;
  int n_fail = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;  // 50 MHz

  uart_stick_tx dut_i (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .lcr(lcr),
    .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .txd(txd), .div_sel(div_sel)
  );

  initial begin : tick_gen
    int c = 0;
    forever begin
      @(posedge clk);
      #2;
      baud_tick = (c == 3);
      c = (c + 1) % 4;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  function automatic int exp_par(input logic [7:0] d, input int n, input logic [1:0] m);
    int ones = 0;
    for (int i = 0; i < n; i++) ones += d[i];
    case (m)
      2'b00: return (ones % 2 == 0) ? 1 : 0;
      2'b01: return ones % 2;
      2'b10: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic string par_req(input logic [1:0] m);
    case (m)
      2'b00: return "R4 odd";
      2'b01: return "R5 even";
      2'b10: return "R6 mark";
      default: return "R7 space";
    endcase
  endfunction

  // Send one character with control l; switch control to l_mid after accept.
  task automatic send_frame(input logic [7:0] d, input logic [7:0] l, input logic [7:0] l_mid);
    int n, p, stop_t, total, t;
    logic [15:0] smp;
    logic [7:0] got, want;
    bit brk, low_all, changed;
    n = 5 + int'(l[1:0]);
    p = l[3] ? 1 : 0;
    stop_t = !l[2] ? 16 : (l[1:0] == 2'b00 ? 24 : 32);
    total = 16 * (1 + n + p) + stop_t;
    brk = l[6];
    changed = (l_mid != l);
    lcr = l;
    tx_data = d;
    tx_valid = 1'b1;
    do @(negedge clk); while (!tx_ready);
    step();
    tx_valid = 1'b0;
    lcr = l_mid;
    t = 0;
    smp = '1;
    low_all = 1'b1;
    @(negedge clk);
    check(tx_ready == 1'b0, "R11 ready low after accept", tx_ready, 0);
    while (1) begin
      if (tx_ready) break;
      if (txd) low_all = 1'b0;
      if (baud_tick) begin
        t++;
        if (t % 16 == 8 && t / 16 < 16) smp[t / 16] = txd;
      end
      @(negedge clk);
    end
    check(t == total, changed ? "R12 frame length kept" :
          (l[2] ? "R8 stop length" : (p == 0 ? "R3 no parity length" : "R13 bit time")),
          t, total);
    if (brk) begin
      check(low_all, "R9 line low through consumed frame", low_all, 1);
    end else begin
      check(smp[0] == 1'b0, "R2 start bit", smp[0], 0);
      got = '0;
      want = '0;
      for (int i = 0; i < n; i++) begin
        got[i] = smp[1 + i];
        want[i] = d[i];
      end
      check(got == want, changed ? "R12 data kept" : "R2 data bits", got, want);
      if (p == 1)
        check(int'(smp[1 + n]) == exp_par(d, n, l[5:4]), par_req(l[5:4]),
              smp[1 + n], exp_par(d, n, l[5:4]));
      check(smp[1 + n + p] == 1'b1, "R2 stop bit", smp[1 + n + p], 1);
      if (l[2] && l[1:0] != 2'b00)
        check(smp[2 + n + p] == 1'b1, "R8 second stop bit", smp[2 + n + p], 1);
    end
  endtask

  initial begin : main
    logic [7:0] d, l, lm;
    void'($urandom(32'd1234));
    repeat (3) step();
    @(negedge clk);
    check(txd == 1'b1, "R1 txd in reset", txd, 1);
    check(tx_ready == 1'b1, "R1 ready in reset", tx_ready, 1);
    check(div_sel == 1'b0, "R1 div_sel in reset", div_sel, 0);
    step();
    rst = 1'b0;
    repeat (2) step();
    @(negedge clk);
    check(txd == 1'b1 && tx_ready == 1'b1, "R1 idle after reset", {txd, tx_ready}, 3);

    // Register select follows bit 7, one cycle later
    step(); lcr = 8'h80;
    step(); @(negedge clk);
    check(div_sel == 1'b1, "R10 div_sel set", div_sel, 1);
    step(); lcr = 8'h00;
    step(); @(negedge clk);
    check(div_sel == 1'b0, "R10 div_sel clear", div_sel, 0);

    // Directed parity modes on 8-bit words
    send_frame(8'hA5, 8'h0B, 8'h0B);  // odd
    send_frame(8'hA5, 8'h1B, 8'h1B);  // even
    send_frame(8'h5A, 8'h2B, 8'h2B);  // mark
    send_frame(8'hFF, 8'h3B, 8'h3B);  // space
    send_frame(8'h3C, 8'h33, 8'h33);  // parity disabled, bits 5:4 set (R3)
    send_frame(8'hF5, 8'h04, 8'h04);  // 5-bit, 1.5 stop (R8)
    send_frame(8'h81, 8'h87, 8'h87);  // div_sel set during frame, 8 bits 2 stop (R10)
    send_frame(8'h55, 8'h08, 8'h3F);  // mid-frame change (R12)

    // Break
    step(); lcr = 8'h43;
    step(); @(negedge clk);
    check(txd == 1'b0, "R9 break low", txd, 1'b0);
    send_frame(8'hFF, 8'h43, 8'h43);
    step(); lcr = 8'h03;
    step(); @(negedge clk);
    check(txd == 1'b1, "R9 line back after break", txd, 1);

    // Random frames
    for (int k = 0; k < 60; k++) begin
      d = 8'($urandom);
      l = 8'($urandom) & 8'hBF;
      lm = (k % 2 == 1) ? (8'($urandom) & 8'hBF) : l;
      send_frame(d, l, lm);
      if ($urandom % 3 == 0) repeat ($urandom % 5) step();
    end

    if (!done_flag) begin
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule